// File: doc/BRIEF.md
# Four-Lane Serial Audio Transmitter

This block sends audio to four serial data lines that share one bit clock and one left/right clock. Both clocks are derived from one of two master clock tick streams. The bit clock rate is set by a divide code. Each frame lasts 64 bit clocks: a 32-bit left slot, then a 32-bit right slot. Every lane has its own buffer of left/right sample pairs. At the start of each frame, a running lane takes one pair from its buffer. It places each sample in its slot according to the lane's width and alignment setting, then shifts the slot out MSB first. Data changes on the falling edge of the bit clock.

Each lane is governed by a four-state machine. The states are LANE_IDLE, LANE_ARM, LANE_RUN and LANE_DRAIN. The transitions are:
- IDLE→ARM when the lane enable is seen.
- ARM→IDLE if the enable drops before a frame start.
- ARM→RUN at a frame start while enabled.
- RUN→DRAIN when the enable is cleared.
- DRAIN→RUN if the enable returns before the frame ends.
- DRAIN→IDLE at a frame start.

Lanes enabled in the same cycle therefore start at the same frame start, in lockstep. The run-status output is high in RUN and DRAIN. When a frame starts and the lane's buffer is empty, the lane sends zeros for the whole frame and raises a sticky empty flag. A buffer reset pulse empties the lane's buffer and clears that flag.

Top module: `quad_serial_audio_tx`

## Requirements
- R1: While reset is held, bclk, lrck, every sdata line, run_status, buf_full and buf_empty_flag are all 0.
- R2: The bit clock period, counted in ticks of the selected master clock, is 2 for div_code 1, 4 for code 2, 8 for code 4 and 12 for code 6. Every other code gives a period of 2. The high and low phases are equal.
- R3: mclk_sel=0 takes mclk0_tick as the source and mclk_sel=1 takes mclk1_tick.
- R4: A frame lasts 64 bit clocks. lrck is 0 for the 32 bit clocks of the left slot and 1 for the 32 bit clocks of the right slot. lrck and the data change only at bit clock falling edges, and slot bit 31 is sent first.
- R5: A lane whose enable is seen starts at the next frame start, and its run_status rises at that frame start. Lanes enabled in the same cycle rise together.
- R6: A lane whose enable is cleared finishes the current frame. Its run_status falls at the frame start that follows, and a lane that is not running drives sdata low.
- R7: The per-lane width code is 2 bits at width_code[2i+1:2i]. Code 0 (and reserved code 1) sends sample bits 15:0 in slot bits 31:16. Code 2 sends 20 bits and code 3 sends 24 bits. For codes 2 and 3, msb_align[i]=1 places the sample in the top slot bits and msb_align[i]=0 places it in the bottom slot bits. Slot bits not filled by the sample are 0.
- R8: When a frame starts on a running lane with an empty buffer, both slots of that frame are sent as zeros and buf_empty_flag[i] is set. The flag stays set until a buffer reset.
- R9: A one-cycle pulse on buf_rst[i] empties lane i's buffer and clears its empty flag in the next cycle. Each buffer holds FIFO_DEPTH (default 4) pairs, buf_full[i] shows when it is full, and a push into a full buffer is dropped.
- R10: bclk_off=1 holds bclk at 0, and lrck_off=1 holds lrck at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk0_tick | input | 1 | Master clock 0 tick (one clk wide) |
| mclk1_tick | input | 1 | Master clock 1 tick (one clk wide) |
| mclk_sel | input | 1 | Master clock source select |
| div_code | input | 4 | Bit clock divide code |
| bclk_off | input | 1 | Force bit clock output low |
| lrck_off | input | 1 | Force left/right clock output low |
| chan_en | input | NUM_CH | Per-lane enable |
| width_code | input | 2*NUM_CH | Per-lane sample width code |
| msb_align | input | NUM_CH | Per-lane slot alignment |
| buf_rst | input | NUM_CH | Per-lane buffer reset pulse |
| push | input | NUM_CH | Per-lane pair write strobe |
| push_left | input | 24 | Left sample to write |
| push_right | input | 24 | Right sample to write |
| buf_full | output | NUM_CH | Per-lane buffer full |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Left/right clock |
| sdata | output | NUM_CH | Serial data lines |
| run_status | output | NUM_CH | Per-lane running indication |
| buf_empty_flag | output | NUM_CH | Sticky buffer-empty flags |

## Verification
A frame start is the bit clock falling edge that ends bit 63. run_status changes at that same clk edge, together with the falling bit clock, the new lrck level and the first data bit. The bench therefore waits for run_status to change and then checks lrck and the lane mask in that very sample. Data bits are captured at each rising bit clock, which comes half a bit period after the data changed, and the bench counts slot positions from the lrck level seen there. Buffer reset and buffer full take effect one clk after the strobe, so the bench samples them at the next falling clk edge. Enables are applied only just after lrck rises, far from any frame start, so that a "not yet running" check two cycles later cannot meet a boundary.

// File: rtl/qsat_pkg.sv
package qsat_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int PAIR_W     = 2 * SAMPLE_W;

    typedef enum logic [1:0] {
        LANE_IDLE  = 2'd0,
        LANE_ARM   = 2'd1,
        LANE_RUN   = 2'd2,
        LANE_DRAIN = 2'd3
    } lane_state_e;

    // Place one sample inside a 32-bit slot according to width and alignment.
    function automatic logic [SLOT_BITS-1:0] place_sample(
        input logic [SAMPLE_W-1:0] s,
        input logic [1:0]          code,
        input logic                top_side
    );
        logic [SLOT_BITS-1:0] r;
        unique case (code)
            2'd2:    r = top_side ? {s[19:0], 12'd0} : {12'd0, s[19:0]};
            2'd3:    r = top_side ? {s, 8'd0} : {8'd0, s};
            default: r = {s[15:0], 16'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qsat_bclk_gen.sv
module qsat_bclk_gen
    import qsat_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick0,
    input  logic             tick1,
    input  logic             sel,
    input  logic [DIV_W-1:0] div_code,
    output logic             bclk_q,
    output logic             lrck_q,
    output logic [IDX_W-1:0] bit_idx,
    output logic             frame_start
);

    logic             tick;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;
    logic             toggle;
    logic             fall_evt;

    assign tick = sel ? tick1 : tick0;

    // Half period in selected-source ticks.
    always_comb begin
        unique case (div_code)
            DIV_W'(2): half = DIV_W'(2);
            DIV_W'(4): half = DIV_W'(4);
            DIV_W'(6): half = DIV_W'(6);
            default:   half = DIV_W'(1);
        endcase
    end

    assign toggle      = tick && (cnt >= half - DIV_W'(1));
    assign fall_evt    = toggle && bclk_q;
    assign frame_start = fall_evt && (bit_idx == IDX_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            bclk_q <= 1'b0;
        end else if (toggle) begin
            cnt    <= '0;
            bclk_q <= ~bclk_q;
        end else if (tick) begin
            cnt    <= cnt + DIV_W'(1);
        end
    end

    // Position counter: starts at the last bit so the first fall opens a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= IDX_W'(FRAME_BITS - 1);
            lrck_q  <= 1'b0;
        end else if (fall_evt) begin
            bit_idx <= bit_idx + IDX_W'(1);
            lrck_q  <= (bit_idx + IDX_W'(1)) >= IDX_W'(SLOT_BITS);
        end
    end

endmodule

// File: rtl/qsat_pair_fifo.sv
module qsat_pair_fifo
    import qsat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] head_left,
    output logic [SAMPLE_W-1:0] head_right,
    output logic                empty,
    output logic                full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PAIR_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push;
    logic              do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    assign head_left  = mem[rd_ptr][PAIR_W-1:SAMPLE_W];
    assign head_right = mem[rd_ptr][SAMPLE_W-1:0];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= {in_left, in_right};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/qsat_lane.sv
module qsat_lane
    import qsat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                frame_start,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic [1:0]          width_code,
    input  logic                top_side,
    input  logic                buf_rst,
    input  logic [SAMPLE_W-1:0] head_left,
    input  logic [SAMPLE_W-1:0] head_right,
    input  logic                fifo_empty,
    output logic                pop,
    output logic                sdata,
    output logic                running,
    output logic                empty_flag
);

    lane_state_e            state;
    lane_state_e            state_nxt;
    logic                   load;
    logic [FRAME_BITS-1:0]  word;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LANE_IDLE;
        else        state <= state_nxt;
    end

    // Next state.
    always_comb begin
        state_nxt = state;
        unique case (state)
            LANE_IDLE:  if (en) state_nxt = LANE_ARM;
            LANE_ARM: begin
                if (!en)              state_nxt = LANE_IDLE;
                else if (frame_start) state_nxt = LANE_RUN;
            end
            LANE_RUN:   if (!en) state_nxt = LANE_DRAIN;
            LANE_DRAIN: begin
                if (frame_start) state_nxt = LANE_IDLE;
                else if (en)     state_nxt = LANE_RUN;
            end
        endcase
    end

    // State-decoded outputs.
    always_comb begin
        running = 1'b0;
        load    = 1'b0;
        unique case (state)
            LANE_IDLE:  ;
            LANE_ARM:   load = frame_start && en;
            LANE_RUN: begin
                running = 1'b1;
                load    = frame_start;
            end
            LANE_DRAIN: running = 1'b1;
        endcase
    end

    assign pop = load && !fifo_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (load) begin
            if (fifo_empty) word <= '0;
            else            word <= {place_sample(head_left, width_code, top_side),
                                     place_sample(head_right, width_code, top_side)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || buf_rst)        empty_flag <= 1'b0;
        else if (load && fifo_empty)  empty_flag <= 1'b1;
    end

    assign sdata = running ? word[IDX_W'(FRAME_BITS - 1) - bit_idx] : 1'b0;

endmodule

// File: rtl/quad_serial_audio_tx.sv
module quad_serial_audio_tx
    import qsat_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mclk0_tick,
    input  logic                  mclk1_tick,
    input  logic                  mclk_sel,
    input  logic [DIV_W-1:0]      div_code,
    input  logic                  bclk_off,
    input  logic                  lrck_off,
    input  logic [NUM_CH-1:0]     chan_en,
    input  logic [2*NUM_CH-1:0]   width_code,
    input  logic [NUM_CH-1:0]     msb_align,
    input  logic [NUM_CH-1:0]     buf_rst,
    input  logic [NUM_CH-1:0]     push,
    input  logic [SAMPLE_W-1:0]   push_left,
    input  logic [SAMPLE_W-1:0]   push_right,
    output logic [NUM_CH-1:0]     buf_full,
    output logic                  bclk,
    output logic                  lrck,
    output logic [NUM_CH-1:0]     sdata,
    output logic [NUM_CH-1:0]     run_status,
    output logic [NUM_CH-1:0]     buf_empty_flag
);

    logic             bclk_int;
    logic             lrck_int;
    logic [IDX_W-1:0] bit_idx;
    logic             frame_start;

    qsat_bclk_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick0       (mclk0_tick),
        .tick1       (mclk1_tick),
        .sel         (mclk_sel),
        .div_code    (div_code),
        .bclk_q      (bclk_int),
        .lrck_q      (lrck_int),
        .bit_idx     (bit_idx),
        .frame_start (frame_start)
    );

    assign bclk = bclk_int & ~bclk_off;
    assign lrck = lrck_int & ~lrck_off;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        logic [SAMPLE_W-1:0] hl;
        logic [SAMPLE_W-1:0] hr;
        logic                f_empty;
        logic                f_pop;

        qsat_pair_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (buf_rst[g]),
            .push       (push[g]),
            .in_left    (push_left),
            .in_right   (push_right),
            .pop        (f_pop),
            .head_left  (hl),
            .head_right (hr),
            .empty      (f_empty),
            .full       (buf_full[g])
        );

        qsat_lane u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .en          (chan_en[g]),
            .frame_start (frame_start),
            .bit_idx     (bit_idx),
            .width_code  (width_code[2*g +: 2]),
            .top_side    (msb_align[g]),
            .buf_rst     (buf_rst[g]),
            .head_left   (hl),
            .head_right  (hr),
            .fifo_empty  (f_empty),
            .pop         (f_pop),
            .sdata       (sdata[g]),
            .running     (run_status[g]),
            .empty_flag  (buf_empty_flag[g])
        );
    end

endmodule

// File: rtl/qsat_checker.sv
module qsat_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bclk,
    input logic              lrck,
    input logic              bclk_off,
    input logic              lrck_off,
    input logic [NUM_CH-1:0] sdata,
    input logic [NUM_CH-1:0] run_status,
    input logic [NUM_CH-1:0] chan_en,
    input logic [NUM_CH-1:0] buf_rst,
    input logic [NUM_CH-1:0] buf_empty_flag,
    input logic              frame_start
);

    a_r4_lrck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!bclk_off && !lrck_off && $past(!bclk_off && !lrck_off) && !$stable(lrck))
            |-> $fell(bclk));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        a_r5_start_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_status[i]) |-> $past(frame_start));

        a_r5_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_status[i]) |-> $past(chan_en[i]));

        a_r6_stop_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(run_status[i]) |-> $past(frame_start));

        a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !run_status[i] |-> !sdata[i]);

        a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_empty_flag[i] && !buf_rst[i]) |=> buf_empty_flag[i]);

        a_r9_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            buf_rst[i] |=> !buf_empty_flag[i]);
    end

endmodule

bind quad_serial_audio_tx qsat_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bclk           (bclk),
    .lrck           (lrck),
    .bclk_off       (bclk_off),
    .lrck_off       (lrck_off),
    .sdata          (sdata),
    .run_status     (run_status),
    .chan_en        (chan_en),
    .buf_rst        (buf_rst),
    .buf_empty_flag (buf_empty_flag),
    .frame_start    (frame_start)
);

// File: tb/quad_serial_audio_tx_tb.sv
module quad_serial_audio_tx_tb;

    localparam int NCH = 4;
    localparam int DEP = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            mclk0_tick;
    logic            mclk1_tick;
    logic            mclk_sel;
    logic [3:0]      div_code;
    logic            bclk_off;
    logic            lrck_off;
    logic [NCH-1:0]  chan_en;
    logic [2*NCH-1:0] width_code;
    logic [NCH-1:0]  msb_align;
    logic [NCH-1:0]  buf_rst;
    logic [NCH-1:0]  push;
    logic [23:0]     push_left;
    logic [23:0]     push_right;
    logic [NCH-1:0]  buf_full;
    logic            bclk;
    logic            lrck;
    logic [NCH-1:0]  sdata;
    logic [NCH-1:0]  run_status;
    logic [NCH-1:0]  buf_empty_flag;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    quad_serial_audio_tx #(.NUM_CH(NCH), .FIFO_DEPTH(DEP), .DIV_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .mclk0_tick(mclk0_tick), .mclk1_tick(mclk1_tick),
        .mclk_sel(mclk_sel), .div_code(div_code), .bclk_off(bclk_off), .lrck_off(lrck_off),
        .chan_en(chan_en), .width_code(width_code), .msb_align(msb_align), .buf_rst(buf_rst),
        .push(push), .push_left(push_left), .push_right(push_right), .buf_full(buf_full),
        .bclk(bclk), .lrck(lrck), .sdata(sdata), .run_status(run_status),
        .buf_empty_flag(buf_empty_flag)
    );

    // Master tick sources: source 0 every clk, source 1 one clk in three.
    int t1_cnt = 0;
    always @(negedge clk) begin
        mclk0_tick <= 1'b1;
        t1_cnt     <= (t1_cnt == 2) ? 0 : t1_cnt + 1;
        mclk1_tick <= (t1_cnt == 2);
    end

    // Serial receiver: takes a bit at each rising bit clock.
    logic        cap_on = 1'b0;
    logic        rx_prev_b = 1'b0;
    logic        rx_lr;
    int          rx_pos;
    int          rx_frame;
    logic [31:0] rx_sh [NCH];
    logic [31:0] rx_l  [NCH][8];
    logic [31:0] rx_r  [NCH][8];

    always @(negedge clk) begin
        if (cap_on && bclk && !rx_prev_b) begin
            if (lrck != rx_lr) rx_pos = 0;
            rx_lr = lrck;
            for (int c = 0; c < NCH; c++) begin
                rx_sh[c] = {rx_sh[c][30:0], sdata[c]};
                if (rx_pos == 31 && rx_frame < 8) begin
                    if (lrck) rx_r[c][rx_frame] = rx_sh[c];
                    else      rx_l[c][rx_frame] = rx_sh[c];
                end
            end
            if (rx_pos == 31 && lrck) rx_frame = rx_frame + 1;
            rx_pos = rx_pos + 1;
        end
        rx_prev_b = bclk;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] samp(input int c, input int k, input bit right);
        logic [23:0] v;
        v = 24'h9ABCDE ^ (24'(c) << 20) ^ (24'(k) * 24'h111111);
        return right ? ~v : v;
    endfunction

    function automatic logic [31:0] exp_slot(input logic [23:0] s, input logic [1:0] code,
                                              input logic top);
        logic [31:0] w;
        w = {8'd0, s};
        if (code == 2'd3)      return top ? (w << 8) : w;
        else if (code == 2'd2) return top ? ((w & 32'hFFFFF) << 12) : (w & 32'hFFFFF);
        else                   return (w & 32'hFFFF) << 16;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_bclk_rise();
        logic p;
        p = bclk;
        forever begin
            @(negedge clk);
            if (bclk && !p) break;
            p = bclk;
        end
    endtask

    task automatic wait_lrck_rise();
        logic p;
        p = lrck;
        forever begin
            @(negedge clk);
            if (lrck && !p) break;
            p = lrck;
        end
    endtask

    task automatic push_pair(input logic [NCH-1:0] m, input logic [23:0] l, input logic [23:0] r);
        push = m; push_left = l; push_right = r;
        @(negedge clk);
        push = '0;
    endtask

    task automatic start_capture();
        rx_pos = 0; rx_lr = 1'b0; rx_frame = 0;
        cap_on = 1'b1;
    endtask

    task automatic wait_run_change(input logic [NCH-1:0] from);
        while (run_status == from) @(negedge clk);
    endtask

    // R1 and R10
    task automatic t_reset_and_off();
        int seen;
        rst_n = 1'b0;
        cycles(4);
        check("R1 bclk", bclk, 0);
        check("R1 lrck", lrck, 0);
        check("R1 sdata", sdata, 0);
        check("R1 run_status", run_status, 0);
        check("R1 flags", {buf_full, buf_empty_flag}, 0);
        rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bclk || lrck) seen++;
        end
        check("R10 outputs held low", seen, 0);
        bclk_off = 1'b0; lrck_off = 1'b0;
        wait_lrck_rise();
        check("R10 lrck released", lrck, 1);
    endtask

    task automatic measure(output int p);
        wait_bclk_rise();
        p = 0;
        forever begin
            @(negedge clk); p++;
            if (bclk && !rx_prev_b) break;
        end
    endtask

    // R2 and R3
    task automatic t_divider();
        int codes [5] = '{1, 2, 4, 6, 3};
        int expd  [5] = '{2, 4, 8, 12, 2};
        int p;
        for (int i = 0; i < 5; i++) begin
            div_code = 4'(codes[i]);
            cycles(40);
            measure(p);
            check($sformatf("R2 period code %0d", codes[i]), p, expd[i]);
        end
        mclk_sel = 1'b1; div_code = 4'd2;
        cycles(60);
        measure(p);
        check("R3 source 1 period", p, 12);
        mclk_sel = 1'b0; div_code = 4'd1;
        cycles(40);
        measure(p);
        check("R3 source 0 period", p, 2);
    endtask

    // R4
    task automatic t_frame();
        int hi, lo;
        wait_lrck_rise();
        hi = 0;
        while (lrck) begin
            @(negedge clk);
            if (bclk && !rx_prev_b && lrck) hi++;
        end
        lo = 0;
        while (!lrck) begin
            @(negedge clk);
            if (bclk && !rx_prev_b && !lrck) lo++;
        end
        check("R4 right slot bits", hi, 32);
        check("R4 left slot bits", lo, 32);
    endtask

    // R5, R6, R7, R8
    task automatic t_stream();
        width_code = {2'd0, 2'd2, 2'd3, 2'd3};
        msb_align  = 4'b0110;
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < NCH; c++)
                push_pair(4'(1 << c), samp(c, k, 0), samp(c, k, 1));
        wait_lrck_rise();
        chan_en = 4'hF;
        cycles(2);
        check("R5 waits for frame start", run_status, 0);
        wait_run_change(4'h0);
        check("R5 lockstep start", run_status, 4'hF);
        check("R5 start on left slot", lrck, 0);
        start_capture();
        while (rx_frame < 3) @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 2; k++) begin
                check($sformatf("R7 lane %0d frame %0d left", c, k), rx_l[c][k],
                      exp_slot(samp(c, k, 0), width_code[2*c +: 2], msb_align[c]));
                check($sformatf("R7 lane %0d frame %0d right", c, k), rx_r[c][k],
                      exp_slot(samp(c, k, 1), width_code[2*c +: 2], msb_align[c]));
            end
            check($sformatf("R8 lane %0d empty frame", c), {rx_l[c][2], rx_r[c][2]}, 0);
        end
        check("R8 flags set", buf_empty_flag, 4'hF);
        wait_lrck_rise();
        chan_en = 4'h0;
        cycles(2);
        check("R6 still running mid frame", run_status, 4'hF);
        wait_run_change(4'hF);
        check("R6 stop together", run_status, 0);
        check("R6 stop at frame start", lrck, 0);
        cap_on = 1'b0;
        cycles(3);
        check("R6 lines low when stopped", sdata, 0);
        check("R8 flags sticky", buf_empty_flag, 4'hF);
    endtask

    // R9
    task automatic t_flush();
        buf_rst = 4'hF;
        @(negedge clk);
        buf_rst = 4'h0;
        check("R9 flags cleared", buf_empty_flag, 0);
        width_code = {2'd0, 2'd0, 2'd1, 2'd2};
        msb_align  = 4'b0000;
        for (int k = 0; k <= DEP; k++) push_pair(4'b0001, samp(0, k, 0), samp(0, k, 1));
        push_pair(4'b0010, samp(1, 0, 0), samp(1, 0, 1));
        push_pair(4'b0010, samp(1, 1, 0), samp(1, 1, 1));
        check("R9 full only lane 0", buf_full, 4'b0001);
        buf_rst = 4'b0010;
        @(negedge clk);
        buf_rst = 4'h0;
        wait_lrck_rise();
        chan_en = 4'b0011;
        wait_run_change(4'h0);
        check("R5 two lanes start", run_status, 4'b0011);
        start_capture();
        while (rx_frame < DEP + 1) @(negedge clk);
        for (int k = 0; k < DEP; k++)
            check($sformatf("R9 lane 0 frame %0d", k), {rx_l[0][k], rx_r[0][k]},
                  {exp_slot(samp(0, k, 0), 2'd2, 1'b0), exp_slot(samp(0, k, 1), 2'd2, 1'b0)});
        check("R9 overflow pair dropped", {rx_l[0][DEP], rx_r[0][DEP]}, 0);
        check("R9 flushed lane sends zeros", {rx_l[1][0], rx_r[1][0]}, 0);
        check("R9 flags after flush run", buf_empty_flag, 4'b0011);
        chan_en = 4'h0;
        wait_run_change(4'b0011);
        cap_on = 1'b0;
        check("R6 stopped", run_status, 0);
    endtask

    initial begin
        rst_n = 1'b0; mclk_sel = 1'b0; div_code = 4'd1;
        bclk_off = 1'b1; lrck_off = 1'b1;
        chan_en = '0; width_code = '0; msb_align = '0; buf_rst = '0;
        push = '0; push_left = '0; push_right = '0;
        t_reset_and_off();
        t_divider();
        t_frame();
        t_stream();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule